// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This controller brings a set of regulator rails up one at a time, in an order that a configuration port sets, and takes them down again in reverse. After it enables a rail, it waits for that rail's power-good input. The rail must then stay good for a programmable settle time before the next rail in the order is enabled. A per-rail ramp timer limits how long a rail may take to report good. When every rail is up, a done flag is raised.

Faults come from three sources: per-rail fault flags, per-rail overvoltage flags, and the ramp timer. A policy input selects the response. The options are to cut every rail at once, to unwind the rails in reverse order, to switch off only the faulted rail and the rails after it in the order, or to retry the whole power-up after a back-off wait, up to a retry limit. An overvoltage always cuts every rail at once. The first fault's kind and rail are kept in a fault code until a host clear. All pins are plain control and status levels. The block carries no data stream, so no valid/ready handshake applies.

Top module: `pwr_seq`

## Requirements
- R1: The rail at slot k of the order is held in bits [k*IW +: IW] of `order_i`, and the field must be a permutation of the rail indices. With `run_i` high in the idle state, the slot 0 rail is enabled on the next edge. Each later slot's rail is enabled only after the previous slot's rail has completed its settle time. At most one enable rises in any cycle.
- R2: When the current rail's power-good is first seen high, the next enable rises after that power-good has been seen high on `settle_i`+1 further consecutive edges. Any edge that sees it low restarts the count.
- R3: If an enabled rail's power-good is still low on the edge where `tmo_i` edges have passed since its enable, a timeout fault (kind 1) is raised for that rail.
- R4: `done_o` is high only while every rail is enabled and the power-up has finished. It is low after reset.
- R5: Fault and overvoltage flags count only for rails that are enabled, and only while the block is powering up or is up. An overvoltage outranks a rail fault, which outranks a timeout. Among rails of the same kind, the lowest index wins. Kind codes are 1 timeout, 2 rail fault, 3 overvoltage. The first fault is latched into `fvalid_o`/`fkind_o`/`frail_o` and does not change until a clear.
- R6: Policy 0 (cut) drops every enable on the edge that detects the fault and enters a latched fault state. In that state `done_o` is low and the enables hold until `clear_i`, which turns every rail off and returns to idle.
- R7: Policy 1 (reverse) disables rails from the current slot down to slot 0, one per `settle_i`+1 cycles, and then enters the latched fault state.
- R8: Policy 2 (isolate) disables the faulted rail and every rail at a later slot. Rails at earlier slots stay enabled until clear.
- R9: Policy 3 (retry) drops every enable and waits `settle`-independent `backoff_i`+1 cycles, then restarts from slot 0. At most `retry_max_i` retries are made between idle visits. One more fault after that enters the latched fault state.
- R10: An overvoltage on an enabled rail drops every enable on the detecting edge, whatever the policy.
- R11: `run_i` low during power-up or while up starts a reverse power-down with the same per-step delay as in R7. It ends in idle with no fault recorded.
- R12: `clear_i` in idle or in the latched fault state wipes the fault code. A later `run_i` starts a new power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 requests power-up, 0 requests power-down |
| clear_i | input | 1 | Host clear of the latched fault |
| pg_i | input | NRAIL | Per-rail power-good |
| rflt_i | input | NRAIL | Per-rail fault flag |
| ov_i | input | NRAIL | Per-rail overvoltage flag |
| policy_i | input | 2 | Fault policy: 0 cut, 1 reverse, 2 isolate, 3 retry |
| order_i | input | NRAIL*IW | Rail index for each slot |
| settle_i | input | DW | Settle time and power-down step delay |
| tmo_i | input | DW | Ramp timeout |
| backoff_i | input | DW | Retry back-off delay |
| retry_max_i | input | RW | Retry limit |
| en_o | output | NRAIL | Regulator enables |
| done_o | output | 1 | All rails up |
| fvalid_o | output | 1 | Fault code valid |
| fkind_o | output | 2 | Fault kind |
| frail_o | output | IW | Faulted rail |

## Verification
Power-up is tried with two different orders and with uneven ramp latencies. The recorded enable sequence shows whether the order field is decoded slot by slot, and a power-good glitch during settling shows whether the stable count restarts. Each fault policy is hit both with a single-cycle fault pulse and with a fault held high. The held fault tells a bounded retry loop apart from an endless one, and the pulse shows a successful retry that keeps its fault code. Simultaneous faults on several rails and of several kinds separate the rank by kind from the rank by index. An overvoltage under the reverse policy shows that it overrides the selected policy.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    S_OFF, S_UP, S_SETTLE, S_ON, S_DOWN, S_BACKOFF, S_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {
    FK_NONE, FK_TIMEOUT, FK_RAILFLT, FK_OVERV
  } fault_kind_e;

  typedef enum logic [1:0] {
    POL_CUT, POL_REVERSE, POL_ISOLATE, POL_RETRY
  } fault_pol_e;
endpackage

// File: rtl/pwrseq_fault_pick.sv
module pwrseq_fault_pick
  import pwrseq_pkg::*;
#(
  parameter int NRAIL = 4,
  parameter int IW    = 2
) (
  input  logic [NRAIL-1:0] en,
  input  logic [NRAIL-1:0] ov,
  input  logic [NRAIL-1:0] flt,
  input  logic             watch,
  input  logic             tmo_hit,
  input  logic [IW-1:0]    tmo_rail,
  output fault_kind_e      kind,
  output logic [IW-1:0]    rail
);
  logic          ov_any, fl_any;
  logic [IW-1:0] ov_rail, fl_rail;

  // lowest index wins: scan from the top, later hits overwrite
  always_comb begin
    ov_any = 1'b0; ov_rail = '0;
    fl_any = 1'b0; fl_rail = '0;
    for (int i = NRAIL-1; i >= 0; i--) begin
      if (ov[i] && en[i])  begin ov_any = 1'b1; ov_rail = IW'(i); end
      if (flt[i] && en[i]) begin fl_any = 1'b1; fl_rail = IW'(i); end
    end
  end

  always_comb begin
    kind = FK_NONE;
    rail = '0;
    if (watch) begin
      if (ov_any)       begin kind = FK_OVERV;   rail = ov_rail;  end
      else if (fl_any)  begin kind = FK_RAILFLT; rail = fl_rail;  end
      else if (tmo_hit) begin kind = FK_TIMEOUT; rail = tmo_rail; end
    end
  end
endmodule

// File: rtl/pwrseq_code_reg.sv
module pwrseq_code_reg
  import pwrseq_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fault_kind_e   kind,
  input  logic [IW-1:0] rail,
  input  logic          clr,
  output logic          valid_q,
  output fault_kind_e   kind_q,
  output logic [IW-1:0] rail_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= FK_NONE;
      rail_q  <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
    end else if (kind != FK_NONE && !valid_q) begin
      valid_q <= 1'b1;
      kind_q  <= kind;
      rail_q  <= rail;
    end
  end

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr) |=> (valid_q && $stable(kind_q) && $stable(rail_q)));
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int NRAIL = 4,
  parameter int DW    = 16,
  parameter int RW    = 3,
  localparam int IW   = (NRAIL > 2) ? $clog2(NRAIL) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                clear_i,
  input  logic [NRAIL-1:0]    pg_i,
  input  logic [NRAIL-1:0]    rflt_i,
  input  logic [NRAIL-1:0]    ov_i,
  input  logic [1:0]          policy_i,
  input  logic [NRAIL*IW-1:0] order_i,
  input  logic [DW-1:0]       settle_i,
  input  logic [DW-1:0]       tmo_i,
  input  logic [DW-1:0]       backoff_i,
  input  logic [RW-1:0]       retry_max_i,
  output logic [NRAIL-1:0]    en_o,
  output logic                done_o,
  output logic                fvalid_o,
  output logic [1:0]          fkind_o,
  output logic [IW-1:0]       frail_o
);
  localparam logic [IW-1:0] LAST = IW'(NRAIL-1);

  seq_state_e        st;
  logic [IW-1:0]     s;
  logic [DW-1:0]     cnt;
  logic [RW-1:0]     rc;
  logic [NRAIL-1:0]  en_q;
  logic              fdown;

  logic [IW-1:0]     s_nxt, s_prv, cur_rail, nxt_rail, prv_rail, first_rail;
  logic              cur_pg, watch, tmo_hit, clr;
  fault_kind_e       fk, fk_q;
  logic [IW-1:0]     fk_rail, fslot;
  fault_pol_e        pol_eff;
  logic [NRAIL-1:0]  keep;

  assign s_nxt      = s + 1'b1;
  assign s_prv      = s - 1'b1;
  assign cur_rail   = order_i[s*IW +: IW];
  assign nxt_rail   = order_i[s_nxt*IW +: IW];
  assign prv_rail   = order_i[s_prv*IW +: IW];
  assign first_rail = order_i[IW-1:0];
  assign cur_pg     = pg_i[cur_rail];
  assign watch      = (st == S_UP) || (st == S_SETTLE) || (st == S_ON);
  assign tmo_hit    = (st == S_UP) && !cur_pg && (cnt == tmo_i);
  assign clr        = clear_i && ((st == S_OFF) || (st == S_FAULT));
  assign pol_eff    = (fk == FK_OVERV) ? POL_CUT : fault_pol_e'(policy_i);

  pwrseq_fault_pick #(.NRAIL(NRAIL), .IW(IW)) u_pick (
    .en(en_q), .ov(ov_i), .flt(rflt_i), .watch(watch),
    .tmo_hit(tmo_hit), .tmo_rail(cur_rail), .kind(fk), .rail(fk_rail)
  );

  pwrseq_code_reg #(.IW(IW)) u_code (
    .clk(clk), .rst_n(rst_n), .kind(fk), .rail(fk_rail), .clr(clr),
    .valid_q(fvalid_o), .kind_q(fk_q), .rail_q(frail_o)
  );

  // slot held by the faulted rail
  always_comb begin
    fslot = '0;
    for (int j = 0; j < NRAIL; j++)
      if (order_i[j*IW +: IW] == fk_rail) fslot = IW'(j);
  end

  // a rail survives isolation when its slot precedes the faulted slot
  for (genvar r = 0; r < NRAIL; r++) begin : g_keep
    logic [IW-1:0] pos;
    always_comb begin
      pos = '0;
      for (int j = 0; j < NRAIL; j++)
        if (order_i[j*IW +: IW] == IW'(r)) pos = IW'(j);
    end
    assign keep[r] = (pos < fslot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; s <= '0; cnt <= '0; rc <= '0; en_q <= '0; fdown <= 1'b0;
    end else begin
      unique case (st)
        S_OFF: begin
          rc <= '0;
          if (run_i) begin
            st <= S_UP; s <= '0; cnt <= '0; en_q[first_rail] <= 1'b1;
          end
        end
        S_UP, S_SETTLE, S_ON: begin
          if (fk != FK_NONE) begin
            unique case (pol_eff)
              POL_CUT:     begin en_q <= '0; st <= S_FAULT; end
              POL_REVERSE: begin
                en_q[cur_rail] <= 1'b0; cnt <= '0; fdown <= 1'b1; st <= S_DOWN;
              end
              POL_ISOLATE: begin en_q <= en_q & keep; st <= S_FAULT; end
              POL_RETRY: begin
                en_q <= '0; cnt <= '0;
                if (rc < retry_max_i) begin rc <= rc + 1'b1; st <= S_BACKOFF; end
                else st <= S_FAULT;
              end
            endcase
          end else if (!run_i) begin
            en_q[cur_rail] <= 1'b0; cnt <= '0; fdown <= 1'b0; st <= S_DOWN;
          end else if (st == S_UP) begin
            if (cur_pg) begin st <= S_SETTLE; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end else if (st == S_SETTLE) begin
            if (!cur_pg) cnt <= '0;
            else if (cnt == settle_i) begin
              if (s == LAST) st <= S_ON;
              else begin
                s <= s_nxt; st <= S_UP; cnt <= '0; en_q[nxt_rail] <= 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
        end
        S_DOWN: begin
          if (cnt == settle_i) begin
            if (s == '0) begin st <= fdown ? S_FAULT : S_OFF; fdown <= 1'b0; end
            else begin s <= s_prv; cnt <= '0; en_q[prv_rail] <= 1'b0; end
          end else cnt <= cnt + 1'b1;
        end
        S_BACKOFF: begin
          if (!run_i) st <= S_FAULT;
          else if (cnt == backoff_i) begin
            st <= S_UP; s <= '0; cnt <= '0; en_q[first_rail] <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_FAULT: begin
          if (clear_i) begin en_q <= '0; st <= S_OFF; end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  assign en_o    = en_q;
  assign done_o  = (st == S_ON);
  assign fkind_o = fk_q;

  // R1
  one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_q & ~$past(en_q)) <= 1);
  // R4
  done_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (&en_q));
  // R10
  ov_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (watch && |(ov_i & en_q)) |=> (en_q == '0));
  // R6
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAULT && !clear_i) |=> (st == S_FAULT && $stable(en_q)));
endmodule

// File: tb/tb_pwr_seq.sv
module tb_pwr_seq;
  localparam int N = 4, IW = 2, DW = 16, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_i = 0, clear_i = 0;
  logic [N-1:0] pg_i = '0, rflt_i = '0, ov_i = '0;
  logic [1:0]   policy_r = 2'd0;
  logic [N*IW-1:0] order_r = 8'b01_11_00_10;   // slots: 2,0,3,1
  logic [DW-1:0] settle_r = 16'd3, tmo_r = 16'd20, backoff_r = 16'd5;
  logic [RW-1:0] rmax_r = 3'd2;
  logic [N-1:0] en_o; logic done_o, fvalid_o; logic [1:0] fkind_o; logic [IW-1:0] frail_o;

  pwr_seq #(.NRAIL(N), .DW(DW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .clear_i(clear_i), .pg_i(pg_i),
    .rflt_i(rflt_i), .ov_i(ov_i), .policy_i(policy_r), .order_i(order_r),
    .settle_i(settle_r), .tmo_i(tmo_r), .backoff_i(backoff_r), .retry_max_i(rmax_r),
    .en_o(en_o), .done_o(done_o), .fvalid_o(fvalid_o), .fkind_o(fkind_o), .frail_o(frail_o));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R4";
  int lat [N] = '{2, 2, 2, 2};
  int ramp [N] = '{0, 0, 0, 0};
  logic [N-1:0] pg_kill = '0, prev_en = '0;
  int rise_q[$], fall_q[$];

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int ord(int k);
    return int'(order_r[k*IW +: IW]);
  endfunction

  function automatic int qcode(int q[$]);
    int v = 0;
    foreach (q[i]) v = v*10 + q[i];
    return v;
  endfunction

  // reference model: 0 idle,1 up,2 settle,3 on,4 down,5 backoff,6 fault
  int m_st, m_s, m_cnt, m_rc, m_fk, m_fr;
  bit [N-1:0] m_en; bit m_fv, m_fdown;

  always @(posedge clk) begin : mdl
    int kind, frl, fs, pol;
    if (!rst_n) begin
      m_st = 0; m_s = 0; m_cnt = 0; m_rc = 0; m_en = '0;
      m_fv = 0; m_fk = 0; m_fr = 0; m_fdown = 0;
    end else begin
      kind = 0; frl = 0;
      if (m_st >= 1 && m_st <= 3) begin
        for (int r = N-1; r >= 0; r--) if (ov_i[r] && m_en[r]) begin kind = 3; frl = r; end
        if (kind == 0)
          for (int r = N-1; r >= 0; r--) if (rflt_i[r] && m_en[r]) begin kind = 2; frl = r; end
        if (kind == 0 && m_st == 1 && !pg_i[ord(m_s)] && m_cnt == int'(tmo_r)) begin
          kind = 1; frl = ord(m_s);
        end
      end
      if (kind != 0 && !m_fv) begin m_fv = 1; m_fk = kind; m_fr = frl; end
      if ((m_st == 0 || m_st == 6) && clear_i) m_fv = 0;
      case (m_st)
        0: begin
          m_rc = 0;
          if (run_i) begin m_st = 1; m_s = 0; m_cnt = 0; m_en[ord(0)] = 1; end
        end
        1, 2, 3: begin
          if (kind != 0) begin
            pol = (kind == 3) ? 0 : int'(policy_r);
            case (pol)
              0: begin m_en = '0; m_st = 6; end
              1: begin m_en[ord(m_s)] = 0; m_cnt = 0; m_fdown = 1; m_st = 4; end
              2: begin
                fs = 0;
                for (int j = 0; j < N; j++) if (ord(j) == frl) fs = j;
                for (int j = fs; j < N; j++) m_en[ord(j)] = 0;
                m_st = 6;
              end
              default: begin
                m_en = '0; m_cnt = 0;
                if (m_rc < int'(rmax_r)) begin m_rc++; m_st = 5; end else m_st = 6;
              end
            endcase
          end else if (!run_i) begin
            m_en[ord(m_s)] = 0; m_cnt = 0; m_fdown = 0; m_st = 4;
          end else if (m_st == 1) begin
            if (pg_i[ord(m_s)]) begin m_st = 2; m_cnt = 0; end else m_cnt++;
          end else if (m_st == 2) begin
            if (!pg_i[ord(m_s)]) m_cnt = 0;
            else if (m_cnt == int'(settle_r)) begin
              if (m_s == N-1) m_st = 3;
              else begin m_s++; m_st = 1; m_cnt = 0; m_en[ord(m_s)] = 1; end
            end else m_cnt++;
          end
        end
        4: begin
          if (m_cnt == int'(settle_r)) begin
            if (m_s == 0) begin m_st = m_fdown ? 6 : 0; m_fdown = 0; end
            else begin m_s--; m_cnt = 0; m_en[ord(m_s)] = 0; end
          end else m_cnt++;
        end
        5: begin
          if (!run_i) m_st = 6;
          else if (m_cnt == int'(backoff_r)) begin
            m_st = 1; m_s = 0; m_cnt = 0; m_en[ord(0)] = 1;
          end else m_cnt++;
        end
        default: if (clear_i) begin m_en = '0; m_st = 0; end
      endcase
    end
  end

  // compare every cycle away from the edge, then emulate the rails
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(cur_req, "en", int'(en_o), int'(m_en));
      chk(cur_req, "done", int'(done_o), int'(m_st == 3));
      chk(cur_req, "fvalid", int'(fvalid_o), int'(m_fv));
      if (m_fv) begin
        chk(cur_req, "fkind", int'(fkind_o), m_fk);
        chk(cur_req, "frail", int'(frail_o), m_fr);
      end
      for (int r = 0; r < N; r++) begin
        if (en_o[r] && !prev_en[r]) rise_q.push_back(r);
        if (!en_o[r] && prev_en[r]) fall_q.push_back(r);
      end
      prev_en = en_o;
    end
    for (int r = 0; r < N; r++) begin
      if (m_en[r]) ramp[r]++; else ramp[r] = 0;
      pg_i[r] = m_en[r] && (ramp[r] >= lat[r]) && !pg_kill[r];
    end
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && !done_o; i++) @(negedge clk);
  endtask

  task automatic go_idle();
    run_i = 0; rflt_i = '0; ov_i = '0; pg_kill = '0; clear_i = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (en_o == '0 && !fvalid_o && !done_o) break;
    end
    clear_i = 0;
    tick(6);
    rise_q.delete(); fall_q.delete();
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R4 reset state
    chk("R4", "reset en", int'(en_o), 0);
    chk("R4", "reset done", int'(done_o), 0);
    chk("R5", "reset fvalid", int'(fvalid_o), 0);

    // R1 R2 power-up in order 2,0,3,1; R5 flag on a disabled rail is ignored
    cur_req = "R1"; rise_q.delete();
    run_i = 1; tick(1);
    rflt_i = 4'b0010; ov_i = 4'b1000; tick(2); rflt_i = '0; ov_i = '0;
    chk("R5", "disabled-rail flag ignored", int'(fvalid_o), 0);
    tick(8); pg_kill[0] = 1; tick(1); pg_kill[0] = 0;   // R2 glitch on rail 0
    cur_req = "R2";
    wait_done();
    chk("R4", "done after power-up", int'(done_o), 1);
    chk("R1", "all enabled", int'(en_o), 15);
    chk("R1", "enable order", qcode(rise_q), 2031);

    // R11 normal power-down
    cur_req = "R11"; fall_q.delete();
    run_i = 0;
    for (int i = 0; i < 100 && en_o != '0; i++) @(negedge clk);
    tick(6);
    chk("R11", "reverse order", qcode(fall_q), 1302);
    chk("R11", "no fault", int'(fvalid_o), 0);
    go_idle();

    // R3 timeout, policy cut R6, clear R12
    cur_req = "R3"; policy_r = 2'd0; lat[3] = 100000;
    run_i = 1;
    for (int i = 0; i < 300 && !fvalid_o; i++) @(negedge clk);
    chk("R3", "kind timeout", int'(fkind_o), 1);
    chk("R3", "rail", int'(frail_o), 3);
    chk("R6", "cut enables", int'(en_o), 0);
    cur_req = "R6"; tick(10);
    chk("R6", "latched", int'(en_o) + int'(done_o), 0);
    lat[3] = 2; cur_req = "R12";
    go_idle();
    chk("R12", "code wiped", int'(fvalid_o), 0);

    // R7 reverse on a rail fault
    cur_req = "R7"; policy_r = 2'd1; run_i = 1; wait_done(); fall_q.delete();
    rflt_i = 4'b0001; tick(1); rflt_i = '0;
    for (int i = 0; i < 100 && en_o != '0; i++) @(negedge clk);
    tick(10);
    chk("R7", "unwind order", qcode(fall_q), 1302);
    chk("R7", "kind", int'(fkind_o), 2);
    chk("R7", "rail", int'(frail_o), 0);
    chk("R7", "held off", int'(en_o) + int'(done_o), 0);
    go_idle();

    // R8 isolate rail 3 (slot 2): rails 2 and 0 stay
    cur_req = "R8"; policy_r = 2'd2; run_i = 1; wait_done();
    rflt_i = 4'b1000; tick(1); rflt_i = '0; tick(5);
    chk("R8", "survivors", int'(en_o), 5);
    chk("R8", "rail", int'(frail_o), 3);
    chk("R8", "done low", int'(done_o), 0);
    go_idle();

    // R10 overvoltage overrides reverse, outranks a rail fault
    cur_req = "R10"; policy_r = 2'd1; run_i = 1; wait_done();
    ov_i = 4'b0010; rflt_i = 4'b0001; tick(1); ov_i = '0; rflt_i = '0;
    chk("R10", "all cut", int'(en_o), 0);
    chk("R10", "kind ov", int'(fkind_o), 3);
    chk("R10", "rail", int'(frail_o), 1);
    go_idle();

    // R5 same kind: lowest index wins
    cur_req = "R5"; policy_r = 2'd0; run_i = 1; wait_done();
    rflt_i = 4'b1001; tick(1); rflt_i = '0;
    chk("R5", "lowest rail", int'(frail_o), 0);
    chk("R5", "kind", int'(fkind_o), 2);
    go_idle();

    // R9 retry exhausted: rail 2 (slot 0) faults on every attempt
    cur_req = "R9"; policy_r = 2'd3; rise_q.delete();
    rflt_i = 4'b0100; run_i = 1; tick(60);
    chk("R9", "attempts", rise_q.size(), 3);
    chk("R9", "latched", int'(en_o) + int'(done_o), 0);
    chk("R9", "kind", int'(fkind_o), 2);
    go_idle();

    // R9 retry succeeds, code kept
    cur_req = "R9"; run_i = 1; wait_done();
    rflt_i = 4'b1000; tick(1); rflt_i = '0; tick(2);
    chk("R9", "restart dropped all", int'(en_o), 0);
    wait_done();
    chk("R9", "back up", int'(done_o), 1);
    chk("R5", "code kept", int'(fvalid_o) * 10 + int'(frail_o), 13);
    go_idle();

    // R1 second order 0,1,2,3 with uneven ramps
    cur_req = "R1"; order_r = 8'b11_10_01_00; lat = '{5, 1, 7, 3};
    run_i = 1; wait_done();
    chk("R1", "enable order", qcode(rise_q), 123);
    chk("R4", "done", int'(done_o), 1);
    go_idle();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule